// File: doc/BRIEF.md
# Word Error Guard with Selectable SEC-DED or Parity

This block guards a 16-bit memory word with either a single-error-correcting, double-error-detecting Hamming code of six check bits or a single parity bit of programmable sense. The mode is picked at run time through a small control register, which comes out of reset with all checking switched off. Word bit 0 is the most significant bit of the bus; in this block that bus bit sits on port index 15 (`bus_data[15]`).

In a memory write cycle the block drives freshly computed check bits toward memory. In a memory read cycle it compares the stored check bits with the word, registers an error classification and a corrected copy of the word, and reports the result one clock after the read. When memory signals that it has let go of the bus, the corrected word is driven one clock later so that the two drivers never overlap. All interfaces are plain bus-cycle pins. The block has no valid/ready handshake and applies no back-pressure: a strobed cycle is always accepted in the clock it appears.

Top module: `edac_guard`

## Requirements
- R1: After reset the mode is off (`cfg_mode` code 00), `err_n` is 1, and `sng_oe`, `fix_oe` and `chk_oe` are 0.
- R2: In SEC-DED mode (code 01) a memory write cycle (`bus_mem`=1, `bus_strobe`=1, `bus_read`=0) sets `chk_oe`=1. `chk_out[4:0]` is the XOR of the positions held by the set data bits. Data port bit k takes the k-th integer from 3 upward that is not a power of two (3,5,6,7,9..15,17..21). `chk_out[5]` makes the XOR of all 16 data bits and all 6 check bits equal 0. `chk_oe` is 0 in every other cycle type.
- R3: In parity modes, even (code 10) and odd (code 11), a memory write drives `chk_out[0]` as the XOR of the data (even) or its inverse (odd). `chk_out[5:1]` are 0.
- R4: With the mode off, `err_n` stays 1 whatever the read data and check bits are, and `chk_oe` stays 0.
- R5: In SEC-DED mode a strobed memory read with a consistent code word leaves `err_n`=1 and `sng_err`=0 in the next cycle, and `fix_data` equals the read word.
- R6: In SEC-DED mode a read whose word has one flipped data bit raises `sng_err` in the next cycle, keeps `err_n`=1, and yields the original word on `fix_data`.
- R7: In SEC-DED mode a read with exactly one flipped check bit is reported as a single error. `fix_data` equals the read word unchanged.
- R8: In SEC-DED mode a read with two flipped bits drives `err_n`=0 and `sng_err`=0 in the next cycle. `err_n` and `sng_err` are never active together.
- R9: In parity mode a strobed memory read whose `bus_chk[0]` disagrees with the selected parity drives `err_n`=0 in the next cycle. A matching read leaves it at 1. `sng_oe` is 0 in parity mode.
- R10: `sng_oe` is 1 exactly when the mode is SEC-DED. `sng_err` is 0 whenever `sng_oe` is 0.
- R11: In SEC-DED mode `fix_oe` rises on the first clock edge at which `mem_release` has been 1 for one full cycle. It falls as soon as `mem_release` is 0. It stays 0 in the other modes.
- R12: Errors are reported only for cycles with `bus_mem`, `bus_strobe` and `bus_read` all 1. A write cycle or an I/O read with corrupt check bits leaves `err_n`=1 and `sng_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads `cfg_mode` into the mode register |
| cfg_mode | input | 2 | Mode code: 00 off, 01 SEC-DED, 10 even parity, 11 odd parity |
| bus_mem | input | 1 | 1 for a memory cycle, 0 for I/O |
| bus_strobe | input | 1 | Data strobe, active high |
| bus_read | input | 1 | 1 read, 0 write |
| bus_data | input | 16 | Data word on the bus |
| bus_chk | input | 6 | Check bits read from memory |
| mem_release | input | 1 | Memory has released the data bus |
| chk_out | output | 6 | Generated check bits for a write |
| chk_oe | output | 1 | Drive enable for `chk_out` |
| err_n | output | 1 | Active-low uncorrectable / parity error |
| sng_err | output | 1 | Corrected single error seen |
| sng_oe | output | 1 | Drive enable for `sng_err` |
| fix_data | output | 16 | Corrected word of the last checked read |
| fix_oe | output | 1 | Drive enable for `fix_data` |

## Verification
The bench builds the block with its default 16-bit word, which gives five Hamming bits plus one overall bit. At that width every one of the 16 data positions and all 6 check positions can be flipped one at a time. Several data patterns cover the generator. Double flips, parity of both senses and the release handshake are all reachable at this width. The bench derives its expected code from the position rule stated in R2 alone.

// File: rtl/edac_pkg.sv
package edac_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_SECDED   = 2'b01,
    MODE_PAR_EVEN = 2'b10,
    MODE_PAR_ODD  = 2'b11
  } edac_mode_e;

  // Hamming bits needed so that 2**p >= data + p + 1
  function automatic int hbits(int dw);
    int p;
    p = 1;
    for (int i = 0; i < 16; i++)
      if ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Code position of data bit k: k-th integer from 3 that is not a power of two
  function automatic int hpos(int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Mask of data bits that feed Hamming bit j
  function automatic logic [63:0] hmask(int j, int dw);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < dw; k++)
      if (((hpos(k) >> j) & 1) != 0) m[k] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/edac_encode.sv
module edac_encode import edac_pkg::*; #(
  parameter int DW = 16,
  parameter int HW = 5
) (
  input  logic [DW-1:0] data,
  output logic [HW-1:0] ham
);
  for (genvar j = 0; j < HW; j++) begin : g_bit
    localparam logic [63:0] MASK = hmask(j, DW);
    assign ham[j] = ^(data & MASK[DW-1:0]);
  end
endmodule

// File: rtl/edac_decode.sv
module edac_decode import edac_pkg::*; #(
  parameter int DW = 16,
  parameter int HW = 5
) (
  input  logic [DW-1:0] data,
  input  logic [HW:0]   chk,
  input  logic [HW-1:0] ham,
  output logic [DW-1:0] corr,
  output logic          single,
  output logic          multi
);
  logic [HW-1:0] syn;
  logic          ovl;
  logic [DW-1:0] flip;
  logic          syn_zero;
  logic          syn_one;
  logic          hit;

  assign syn      = chk[HW-1:0] ^ ham;
  assign ovl      = ^{data, chk};
  assign syn_zero = (syn == '0);
  assign syn_one  = !syn_zero && ((syn & (syn - 1'b1)) == '0);

  for (genvar k = 0; k < DW; k++) begin : g_flip
    localparam int POS = hpos(k);
    assign flip[k] = (int'(syn) == POS);
  end

  assign hit = |flip;

  always_comb begin
    single = 1'b0;
    multi  = 1'b0;
    corr   = data;
    if (ovl) begin
      if (syn_zero || syn_one) begin
        single = 1'b1;               // a check bit alone is wrong
      end else if (hit) begin
        single = 1'b1;
        corr   = data ^ flip;
      end else begin
        multi  = 1'b1;               // syndrome outside the code
      end
    end else if (!syn_zero) begin
      multi = 1'b1;
    end
  end
endmodule

// File: rtl/edac_guard.sv
module edac_guard import edac_pkg::*; #(
  parameter  int DATA_W = 16,
  localparam int HAM_W  = hbits(DATA_W),
  localparam int CHK_W  = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              bus_mem,
  input  logic              bus_strobe,
  input  logic              bus_read,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CHK_W-1:0]  bus_chk,
  input  logic              mem_release,
  output logic [CHK_W-1:0]  chk_out,
  output logic              chk_oe,
  output logic              err_n,
  output logic              sng_err,
  output logic              sng_oe,
  output logic [DATA_W-1:0] fix_data,
  output logic              fix_oe
);
  edac_mode_e        mode_q;
  logic              err_q, sng_q, rel_q;
  logic [DATA_W-1:0] fix_q;

  logic [HAM_W-1:0]  ham;
  logic [DATA_W-1:0] corr;
  logic              single, multi;
  logic              on_secded, on_parity, enabled;
  logic              par_bit, par_bad, rd_chk;

  edac_encode #(.DW(DATA_W), .HW(HAM_W)) i_enc (
    .data (bus_data),
    .ham  (ham)
  );

  edac_decode #(.DW(DATA_W), .HW(HAM_W)) i_dec (
    .data   (bus_data),
    .chk    (bus_chk),
    .ham    (ham),
    .corr   (corr),
    .single (single),
    .multi  (multi)
  );

  assign on_secded = (mode_q == MODE_SECDED);
  assign on_parity = (mode_q == MODE_PAR_EVEN) || (mode_q == MODE_PAR_ODD);
  assign enabled   = on_secded || on_parity;

  assign par_bit = (mode_q == MODE_PAR_ODD) ? ~(^bus_data) : ^bus_data;
  assign par_bad = bus_chk[0] ^ par_bit;
  assign rd_chk  = enabled && bus_mem && bus_strobe && bus_read;

  // write side: check bits toward memory
  always_comb begin
    chk_out = '0;
    if (on_secded)      chk_out = {^{bus_data, ham}, ham};
    else if (on_parity) chk_out[0] = par_bit;
  end
  assign chk_oe = enabled && bus_mem && bus_strobe && !bus_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      err_q  <= 1'b0;
      sng_q  <= 1'b0;
      rel_q  <= 1'b0;
      fix_q  <= '0;
    end else begin
      if (cfg_we) mode_q <= edac_mode_e'(cfg_mode);
      err_q <= rd_chk && (on_secded ? multi : par_bad);
      sng_q <= rd_chk && on_secded && single;
      rel_q <= mem_release;
      if (rd_chk && on_secded) fix_q <= corr;
    end
  end

  assign err_n    = !(err_q && enabled);
  assign sng_oe   = on_secded;
  assign sng_err  = sng_q && on_secded;
  assign fix_data = fix_q;
  assign fix_oe   = on_secded && mem_release && rel_q;
endmodule

// File: rtl/edac_guard_chk.sv
module edac_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       bus_mem,
  input logic       bus_strobe,
  input logic       bus_read,
  input logic       mem_release,
  input logic       chk_oe,
  input logic       err_n,
  input logic       sng_err,
  input logic       sng_oe,
  input logic       fix_oe
);
  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (err_n && !chk_oe));

  assert_gen_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_oe |-> (bus_mem && bus_strobe && !bus_read));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> !sng_err);

  assert_single_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sng_oe |-> (!sng_err && !fix_oe));

  assert_release_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix_oe) |-> (mem_release && $past(mem_release)));

  assert_read_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_mem && bus_strobe && bus_read) |=> (err_n && !sng_err));
endmodule

bind edac_guard edac_guard_chk i_chk (.*);

// File: tb/test_edac_guard.sv
module test_edac_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        bus_mem = 1'b0, bus_strobe = 1'b0, bus_read = 1'b0;
  logic [15:0] bus_data = '0;
  logic [5:0]  bus_chk = '0;
  logic        mem_release = 1'b0;
  logic [5:0]  chk_out;
  logic        chk_oe, err_n, sng_err, sng_oe, fix_oe;
  logic [15:0] fix_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edac_guard i_edac_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .bus_mem(bus_mem), .bus_strobe(bus_strobe), .bus_read(bus_read),
    .bus_data(bus_data), .bus_chk(bus_chk), .mem_release(mem_release),
    .chk_out(chk_out), .chk_oe(chk_oe), .err_n(err_n), .sng_err(sng_err),
    .sng_oe(sng_oe), .fix_data(fix_data), .fix_oe(fix_oe)
  );

  function automatic logic [5:0] ref_code(logic [15:0] d);
    logic [4:0] h;
    int cnt;
    h = '0;
    cnt = 0;
    for (int p = 3; p < 32; p++) begin
      if ((p & (p - 1)) != 0 && cnt < 16) begin
        if (d[cnt]) h ^= 5'(p);
        cnt++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] d, logic [5:0] c, logic mem);
    @(negedge clk);
    bus_mem = mem; bus_strobe = 1'b1; bus_read = 1'b1; bus_data = d; bus_chk = c;
    @(negedge clk);
    bus_mem = 1'b0; bus_strobe = 1'b0; bus_read = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 err_n", err_n, 1);
    check("R1 sng_oe", sng_oe, 0);
    check("R1 fix_oe", fix_oe, 0);
    check("R1 chk_oe", chk_oe, 0);
  endtask

  task automatic t_off();
    rd(16'h1234, 6'h3f, 1'b1);
    check("R4 err_n off", err_n, 1);
    @(negedge clk); bus_mem = 1; bus_strobe = 1; bus_read = 0; bus_data = 16'h55aa;
    #1 check("R4 chk_oe off", chk_oe, 0);
    @(negedge clk); bus_mem = 0; bus_strobe = 0;
  endtask

  task automatic t_gen();
    logic [15:0] pats [4] = '{16'h0001, 16'h8000, 16'hbeef, 16'hffff};
    set_mode(2'b01);
    foreach (pats[i]) begin
      @(negedge clk); bus_mem = 1; bus_strobe = 1; bus_read = 0; bus_data = pats[i];
      #1 check("R2 chk_out", chk_out, ref_code(pats[i]));
      check("R2 chk_oe", chk_oe, 1);
    end
    @(negedge clk); bus_mem = 0; bus_strobe = 0;
    #1 check("R2 chk_oe idle", chk_oe, 0);
  endtask

  task automatic t_par_gen();
    set_mode(2'b10);
    @(negedge clk); bus_mem = 1; bus_strobe = 1; bus_read = 0; bus_data = 16'h0007;
    #1 check("R3 even", chk_out, 6'h01);
    set_mode(2'b11);
    @(negedge clk); bus_mem = 1; bus_strobe = 1; bus_read = 0; bus_data = 16'h0007;
    #1 check("R3 odd", chk_out, 6'h00);
    @(negedge clk); bus_data = 16'h0003;
    #1 check("R3 odd2", chk_out, 6'h01);
    @(negedge clk); bus_mem = 0; bus_strobe = 0;
  endtask

  task automatic t_clean();
    set_mode(2'b01);
    rd(16'hc3a5, ref_code(16'hc3a5), 1'b1);
    check("R5 err_n", err_n, 1);
    check("R5 sng_err", sng_err, 0);
    check("R5 fix_data", fix_data, 16'hc3a5);
    check("R10 sng_oe", sng_oe, 1);
  endtask

  task automatic t_single();
    int bits [3] = '{0, 7, 15};
    foreach (bits[i]) begin
      logic [15:0] d = 16'h5a3c;
      rd(d ^ (16'h1 << bits[i]), ref_code(d), 1'b1);
      check("R6 sng_err", sng_err, 1);
      check("R6 err_n", err_n, 1);
      check("R6 fix_data", fix_data, d);
    end
  endtask

  task automatic t_chkbit();
    int bits [2] = '{2, 5};
    foreach (bits[i]) begin
      rd(16'h0f0f, ref_code(16'h0f0f) ^ (6'h1 << bits[i]), 1'b1);
      check("R7 sng_err", sng_err, 1);
      check("R7 fix_data", fix_data, 16'h0f0f);
    end
  endtask

  task automatic t_double();
    rd(16'h1111 ^ 16'h0090, ref_code(16'h1111), 1'b1);
    check("R8 err_n", err_n, 0);
    check("R8 sng_err", sng_err, 0);
    rd(16'h1111 ^ 16'h0001, ref_code(16'h1111) ^ 6'h04, 1'b1);
    check("R8 err_n mixed", err_n, 0);
  endtask

  task automatic t_par_chk();
    set_mode(2'b10);
    check("R9 sng_oe", sng_oe, 0);
    rd(16'h0001, 6'h00, 1'b1);
    check("R9 even bad", err_n, 0);
    rd(16'h0001, 6'h01, 1'b1);
    check("R9 even ok", err_n, 1);
    set_mode(2'b11);
    rd(16'h0001, 6'h01, 1'b1);
    check("R9 odd bad", err_n, 0);
  endtask

  task automatic t_release();
    set_mode(2'b01);
    check("R11 low", fix_oe, 0);
    @(negedge clk); mem_release = 1'b1;
    #1 check("R11 not yet", fix_oe, 0);
    @(negedge clk);
    check("R11 driven", fix_oe, 1);
    mem_release = 1'b0;
    #1 check("R11 drop", fix_oe, 0);
    set_mode(2'b10);
    @(negedge clk); mem_release = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 parity", fix_oe, 0);
    mem_release = 1'b0;
  endtask

  task automatic t_qual();
    set_mode(2'b01);
    @(negedge clk); bus_mem = 1; bus_strobe = 1; bus_read = 0;
    bus_data = 16'h2222; bus_chk = ~ref_code(16'h2222);
    @(negedge clk); bus_mem = 0; bus_strobe = 0;
    check("R12 write", err_n, 1);
    check("R12 write sng", sng_err, 0);
    rd(16'h2222 ^ 16'h0300, ref_code(16'h2222), 1'b0);
    check("R12 io read", err_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_gen();
    t_par_gen();
    t_clean();
    t_single();
    t_chkbit();
    t_double();
    t_par_chk();
    t_release();
    t_qual();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule